// File: doc/BRIEF.md
# Pipeline Control Decode and Stage Propagation

This block produces the control signals for a five-stage in-order pipeline. It decodes the opcode of the instruction that sits in the decode stage. It then splits the resulting control word into three groups by the stage that uses them: execute, memory access and writeback. Each group moves down through the decode/execute, execute/memory and memory/writeback state registers together with its instruction. No stage recomputes anything. Fetch and decode need no per-instruction control, so the block has no outputs for those stages.

The execute stage picks the destination register number: the rd field for register-register operations, the rt field otherwise. That number then travels with the control bits, so writeback always names the register of the instruction that is retiring. Register-register results are written in the fifth stage, the same stage as loads, so the register file write port has a single user in each cycle.

The block also detects a load whose result is needed by the very next instruction. When it sees one, it raises hold outputs for the PC and the fetch/decode register for one cycle and sends a zeroed control word into execute. The datapath, the ALU, the memories, forwarding and branch resolution lie outside this block.

Top module: `ctrl_pipe`

## Requirements
- R1: While rst_ni is low, every control output, every destination output and both hold outputs are 0.
- R2: Opcode 000000 (register-register, bits 31:26) decodes to reg_dst=1, alu_op=10, alu_src=0, branch=0, mem_read=0, mem_write=0, reg_write=1, mem_to_reg=0. The destination is rd (bits 15:11).
- R3: Opcode 100011 (load word) decodes to reg_dst=0, alu_op=00, alu_src=1, branch=0, mem_read=1, mem_write=0, reg_write=1, mem_to_reg=1. The destination is rt (bits 20:16).
- R4: Opcode 101011 (store word) decodes to alu_op=00, alu_src=1, mem_write=1, and drives reg_dst, branch, mem_read, reg_write and mem_to_reg to 0.
- R5: Opcode 000100 (branch-equal) decodes to alu_op=01, branch=1, and drives all other control bits to 0.
- R6: Any other opcode gives an all-zero control word.
- R7: Execute-group outputs reflect an instruction one clock after it is presented on instr_i. Memory-group outputs follow one clock later and writeback outputs one clock after that. The destination number at each stage belongs to the instruction in that stage, also for back-to-back instructions.
- R8: A register-register instruction asserts wb_reg_write_o only in its writeback cycle, the same stage in which a load asserts it. Consecutive register-register and load instructions therefore write in distinct cycles.
- R9: pc_hold_o and ifid_hold_o are high in the cycle in which the execute stage holds a load whose destination is nonzero and equals rs (bits 25:21) of the decode instruction. The same applies when it equals rt of a decode instruction that reads rt, which means register-register, store or branch-equal.
- R10: On the clock after a hold, the execute stage carries an all-zero control word. Hold then drops when the same instruction is presented again, and that bubble writes nothing and accesses no memory as it moves through.
- R11: A load to register 0 never causes a hold. A load followed by a load whose rt equals the first load's destination also causes no hold.
- R12: A dependent instruction placed two or more slots behind a load causes no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 32 | Instruction currently in the decode stage |
| pc_hold_o | output | 1 | Keep the PC unchanged this cycle |
| ifid_hold_o | output | 1 | Keep the fetch/decode register unchanged this cycle |
| ex_reg_dst_o | output | 1 | Execute: select rd as destination |
| ex_alu_op_o | output | 2 | Execute: ALU operation class |
| ex_alu_src_o | output | 1 | Execute: second ALU operand is the immediate |
| ex_dst_o | output | 5 | Execute: selected destination register |
| mem_branch_o | output | 1 | Memory: instruction is a branch-equal |
| mem_read_o | output | 1 | Memory: data memory read |
| mem_write_o | output | 1 | Memory: data memory write |
| mem_dst_o | output | 5 | Memory: destination register |
| wb_reg_write_o | output | 1 | Writeback: write the register file |
| wb_mem_to_reg_o | output | 1 | Writeback: write data comes from memory |
| wb_dst_o | output | 5 | Writeback: destination register |

## Verification
The hardest case to reach is the stall-and-replay sequence. The bench must act as the fetch/decode register: it re-presents the same instruction after a hold, and then follows the zeroed bubble to writeback between the load and its consumer. Directed sequences put a load directly ahead of consumers that match through rs and through rt (register-register, store, branch-equal). Near-miss sequences, which must not hold, cover a load to register 0, a second load whose rt names the first load's destination, and a consumer two slots back.

// File: rtl/ctrl_pipe_pkg.sv
package ctrl_pipe_pkg;

  localparam int OPC_W = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'b00,
    ALU_SUB  = 2'b01,
    ALU_FUNC = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     reg_dst;
    alu_cls_e alu_op;
    logic     alu_src;
  } ex_ctrl_t;

  typedef struct packed {
    logic branch;
    logic mem_read;
    logic mem_write;
  } mem_ctrl_t;

  typedef struct packed {
    logic reg_write;
    logic mem_to_reg;
  } wb_ctrl_t;

  typedef struct packed {
    ex_ctrl_t  ex;
    mem_ctrl_t mem;
    wb_ctrl_t  wb;
  } ctrl_word_t;

endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_pipe_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output ctrl_word_t       ctrl_o,
  output logic             reads_rt_o
);

  always_comb begin
    ctrl_o     = '0;
    reads_rt_o = 1'b0;
    unique case (opcode_i)
      OPC_REG: begin
        ctrl_o.ex.reg_dst   = 1'b1;
        ctrl_o.ex.alu_op    = ALU_FUNC;
        ctrl_o.wb.reg_write = 1'b1;
        reads_rt_o          = 1'b1;
      end
      OPC_LOAD: begin
        ctrl_o.ex.alu_src    = 1'b1;
        ctrl_o.mem.mem_read  = 1'b1;
        ctrl_o.wb.reg_write  = 1'b1;
        ctrl_o.wb.mem_to_reg = 1'b1;
      end
      OPC_STORE: begin
        ctrl_o.ex.alu_src    = 1'b1;
        ctrl_o.mem.mem_write = 1'b1;
        reads_rt_o           = 1'b1;
      end
      OPC_BEQ: begin
        ctrl_o.ex.alu_op  = ALU_SUB;
        ctrl_o.mem.branch = 1'b1;
        reads_rt_o        = 1'b1;
      end
      default: ;
    endcase
  end

  // R3: a memory read always retires through the memory-data writeback path
  always_comb begin
    if (ctrl_o.mem.mem_read) begin
      p_load_writes_mem_r3: assert (ctrl_o.wb.reg_write && ctrl_o.wb.mem_to_reg && !ctrl_o.mem.mem_write);
    end
  end

endmodule

// File: rtl/ctrl_hazard.sv
module ctrl_hazard #(
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ex_mem_read_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic [REG_W-1:0] id_rs_i,
  input  logic [REG_W-1:0] id_rt_i,
  input  logic             id_reads_rt_i,
  output logic             stall_o
);

  logic dst_live, hit_rs, hit_rt;

  assign dst_live = ex_mem_read_i && (ex_dst_i != '0);
  assign hit_rs   = (ex_dst_i == id_rs_i);
  assign hit_rt   = id_reads_rt_i && (ex_dst_i == id_rt_i);
  assign stall_o  = dst_live && (hit_rs || hit_rt);

  // R11: register zero never produces a hold
  p_no_zero_hazard_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (ex_dst_i != '0));

endmodule

// File: rtl/ctrl_pipe_reg.sv
module ctrl_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= '0;
    else            q_o <= d_i;
  end

endmodule

// File: rtl/ctrl_pipe.sv
module ctrl_pipe
  import ctrl_pipe_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int REG_W   = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               pc_hold_o,
  output logic               ifid_hold_o,
  output logic               ex_reg_dst_o,
  output logic [1:0]         ex_alu_op_o,
  output logic               ex_alu_src_o,
  output logic [REG_W-1:0]   ex_dst_o,
  output logic               mem_branch_o,
  output logic               mem_read_o,
  output logic               mem_write_o,
  output logic [REG_W-1:0]   mem_dst_o,
  output logic               wb_reg_write_o,
  output logic               wb_mem_to_reg_o,
  output logic [REG_W-1:0]   wb_dst_o
);

  localparam int OPC_LSB = INSTR_W - OPC_W;
  localparam int RS_LSB  = OPC_LSB - REG_W;
  localparam int RT_LSB  = RS_LSB - REG_W;
  localparam int RD_LSB  = RT_LSB - REG_W;
  localparam int IDEX_W  = $bits(ctrl_word_t) + 2 * REG_W;
  localparam int EXMEM_W = $bits(mem_ctrl_t) + $bits(wb_ctrl_t) + REG_W;
  localparam int MEMWB_W = $bits(wb_ctrl_t) + REG_W;

  // decode stage
  ctrl_word_t       id_ctrl;
  logic             id_reads_rt;
  logic [REG_W-1:0] id_rs, id_rt, id_rd;
  logic             unused_low;

  assign id_rs      = instr_i[RS_LSB +: REG_W];
  assign id_rt      = instr_i[RT_LSB +: REG_W];
  assign id_rd      = instr_i[RD_LSB +: REG_W];
  assign unused_low = ^instr_i[RD_LSB-1:0];

  ctrl_decode u_dec (
    .opcode_i   (instr_i[OPC_LSB +: OPC_W]),
    .ctrl_o     (id_ctrl),
    .reads_rt_o (id_reads_rt)
  );

  // decode/execute
  logic [IDEX_W-1:0] idex_d, idex_q;
  ctrl_word_t        ex_ctrl;
  logic [REG_W-1:0]  ex_rt, ex_rd, ex_dst;
  logic              stall;

  assign idex_d = {id_ctrl, id_rt, id_rd};

  ctrl_pipe_reg #(.W(IDEX_W)) u_idex (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (stall),
    .d_i    (idex_d),
    .q_o    (idex_q)
  );

  assign {ex_ctrl, ex_rt, ex_rd} = idex_q;
  assign ex_dst = ex_ctrl.ex.reg_dst ? ex_rd : ex_rt;

  ctrl_hazard #(.REG_W(REG_W)) u_haz (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ex_mem_read_i (ex_ctrl.mem.mem_read),
    .ex_dst_i      (ex_dst),
    .id_rs_i       (id_rs),
    .id_rt_i       (id_rt),
    .id_reads_rt_i (id_reads_rt),
    .stall_o       (stall)
  );

  // execute/memory
  logic [EXMEM_W-1:0] exmem_q;
  mem_ctrl_t          mem_ctrl;
  wb_ctrl_t           mem_wb;
  logic [REG_W-1:0]   mem_dst;

  ctrl_pipe_reg #(.W(EXMEM_W)) u_exmem (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .d_i    ({ex_ctrl.mem, ex_ctrl.wb, ex_dst}),
    .q_o    (exmem_q)
  );

  assign {mem_ctrl, mem_wb, mem_dst} = exmem_q;

  // memory/writeback
  logic [MEMWB_W-1:0] memwb_q;
  wb_ctrl_t           wb_ctrl;
  logic [REG_W-1:0]   wb_dst;

  ctrl_pipe_reg #(.W(MEMWB_W)) u_memwb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (1'b0),
    .d_i    ({mem_wb, mem_dst}),
    .q_o    (memwb_q)
  );

  assign {wb_ctrl, wb_dst} = memwb_q;

  // outputs
  assign pc_hold_o       = stall;
  assign ifid_hold_o     = stall;
  assign ex_reg_dst_o    = ex_ctrl.ex.reg_dst;
  assign ex_alu_op_o     = ex_ctrl.ex.alu_op;
  assign ex_alu_src_o    = ex_ctrl.ex.alu_src;
  assign ex_dst_o        = ex_dst;
  assign mem_branch_o    = mem_ctrl.branch;
  assign mem_read_o      = mem_ctrl.mem_read;
  assign mem_write_o     = mem_ctrl.mem_write;
  assign mem_dst_o       = mem_dst;
  assign wb_reg_write_o  = wb_ctrl.reg_write;
  assign wb_mem_to_reg_o = wb_ctrl.mem_to_reg;
  assign wb_dst_o        = wb_dst;

  // R10: a hold injects a zero control word into execute
  p_bubble_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> (ex_ctrl == '0));

  // R10: a hold never lasts two consecutive cycles
  p_stall_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> !stall);

  // R4: the memory stage never reads and writes at once
  p_mem_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_read_o && mem_write_o));

  // R8: a memory-data writeback follows a memory read one cycle earlier
  p_wb_load_origin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_read_o && !stall) |=> (wb_reg_write_o && wb_mem_to_reg_o));

endmodule

// File: tb/tb_ctrl_pipe.sv
`timescale 1ns/1ps
module tb_ctrl_pipe;

  localparam logic [31:0] NOP = 32'hFC00_0000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr = NOP;
  logic        pc_hold, ifid_hold, ex_reg_dst, ex_alu_src;
  logic [1:0]  ex_alu_op;
  logic [4:0]  ex_dst, mem_dst, wb_dst;
  logic        mem_branch, mem_read, mem_write, wb_reg_write, wb_mem_to_reg;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ctrl_pipe dut (
    .clk_i(clk), .rst_ni(rst_ni), .instr_i(instr),
    .pc_hold_o(pc_hold), .ifid_hold_o(ifid_hold),
    .ex_reg_dst_o(ex_reg_dst), .ex_alu_op_o(ex_alu_op), .ex_alu_src_o(ex_alu_src), .ex_dst_o(ex_dst),
    .mem_branch_o(mem_branch), .mem_read_o(mem_read), .mem_write_o(mem_write), .mem_dst_o(mem_dst),
    .wb_reg_write_o(wb_reg_write), .wb_mem_to_reg_o(wb_mem_to_reg), .wb_dst_o(wb_dst)
  );

  function automatic logic [31:0] f_reg(input int rd, input int rs, input int rt);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 11'h020};
  endfunction
  function automatic logic [31:0] f_lw(input int rt, input int rs);
    return {6'b100011, 5'(rs), 5'(rt), 16'h0010};
  endfunction
  function automatic logic [31:0] f_sw(input int rt, input int rs);
    return {6'b101011, 5'(rs), 5'(rt), 16'h0004};
  endfunction
  function automatic logic [31:0] f_beq(input int rs, input int rt);
    return {6'b000100, 5'(rs), 5'(rt), 16'h0008};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // present an instruction at the negedge, return hold, step one clock
  task automatic issue(input logic [31:0] ins, output bit hold);
    instr = ins;
    #1;
    hold = pc_hold;
    chk_eq("R9", "pc/ifid hold agree", int'(pc_hold), int'(ifid_hold));
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_ex(input string req, input int rdst, input int op, input int src, input int dst);
    chk_eq(req, "ex_reg_dst", ex_reg_dst, rdst);
    chk_eq(req, "ex_alu_op", ex_alu_op, op);
    chk_eq(req, "ex_alu_src", ex_alu_src, src);
    if (dst >= 0) chk_eq(req, "ex_dst", ex_dst, dst);
  endtask
  task automatic chk_mem(input string req, input int br, input int rd, input int wr, input int dst);
    chk_eq(req, "mem_branch", mem_branch, br);
    chk_eq(req, "mem_read", mem_read, rd);
    chk_eq(req, "mem_write", mem_write, wr);
    if (dst >= 0) chk_eq(req, "mem_dst", mem_dst, dst);
  endtask
  task automatic chk_wb(input string req, input int rw, input int m2r, input int dst);
    chk_eq(req, "wb_reg_write", wb_reg_write, rw);
    chk_eq(req, "wb_mem_to_reg", wb_mem_to_reg, m2r);
    if (dst >= 0) chk_eq(req, "wb_dst", wb_dst, dst);
  endtask

  task automatic flush();
    bit h;
    for (int i = 0; i < 3; i++) issue(NOP, h);
  endtask

  task automatic t_reset();
    #5;
    chk_ex("R1", 0, 0, 0, 0);
    chk_mem("R1", 0, 0, 0, 0);
    chk_wb("R1", 0, 0, 0);
    chk_eq("R1", "hold", pc_hold | ifid_hold, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic t_reg();
    bit h;
    issue(f_reg(3, 1, 2), h);
    chk_ex("R2", 1, 2, 0, 3);
    issue(NOP, h);
    chk_mem("R2", 0, 0, 0, 3);
    chk_ex("R6", 0, 0, 0, -1);
    issue(NOP, h);
    chk_wb("R2", 1, 0, 3);
    flush();
  endtask

  task automatic t_load();
    bit h;
    issue(f_lw(5, 4), h);
    chk_ex("R3", 0, 0, 1, 5);
    issue(NOP, h);
    chk_mem("R3", 0, 1, 0, 5);
    issue(NOP, h);
    chk_wb("R3", 1, 1, 5);
    flush();
  endtask

  task automatic t_store();
    bit h;
    issue(f_sw(6, 4), h);
    chk_ex("R4", 0, 0, 1, 6);
    issue(NOP, h);
    chk_mem("R4", 0, 0, 1, -1);
    issue(NOP, h);
    chk_wb("R4", 0, 0, -1);
    flush();
  endtask

  task automatic t_beq();
    bit h;
    issue(f_beq(1, 2), h);
    chk_ex("R5", 0, 1, 0, -1);
    issue(NOP, h);
    chk_mem("R5", 1, 0, 0, -1);
    issue(NOP, h);
    chk_wb("R5", 0, 0, -1);
    flush();
  endtask

  task automatic t_other();
    bit h;
    issue({6'b001000, 5'd1, 5'd7, 16'h0001}, h);
    chk_ex("R6", 0, 0, 0, -1);
    issue(NOP, h);
    chk_mem("R6", 0, 0, 0, -1);
    issue(NOP, h);
    chk_wb("R6", 0, 0, -1);
    flush();
  endtask

  task automatic t_back_to_back();
    bit h;
    issue(f_reg(7, 1, 2), h);
    issue(f_lw(8, 3), h);
    issue(f_reg(9, 1, 2), h);
    chk_eq("R7", "no hold", h, 0);
    chk_ex("R7", 1, 2, 0, 9);
    chk_mem("R7", 0, 1, 0, 8);
    chk_wb("R8", 1, 0, 7);
    issue(NOP, h);
    chk_wb("R8", 1, 1, 8);
    issue(NOP, h);
    chk_wb("R8", 1, 0, 9);
    flush();
  endtask

  task automatic t_load_use_rs();
    bit h;
    issue(f_lw(10, 1), h);
    chk_eq("R9", "hold before load", h, 0);
    issue(f_reg(11, 10, 2), h);
    chk_eq("R9", "hold on rs match", h, 1);
    chk_ex("R10", 0, 0, 0, -1);
    chk_mem("R10", 0, 1, 0, 10);
    issue(f_reg(11, 10, 2), h);
    chk_eq("R10", "hold on replay", h, 0);
    chk_ex("R10", 1, 2, 0, 11);
    chk_mem("R10", 0, 0, 0, -1);
    chk_wb("R10", 1, 1, 10);
    issue(NOP, h);
    chk_wb("R10", 0, 0, -1);
    chk_mem("R10", 0, 0, 0, 11);
    issue(NOP, h);
    chk_wb("R10", 1, 0, 11);
    flush();
  endtask

  task automatic t_load_use_rt();
    bit h;
    issue(f_lw(12, 1), h);
    issue(f_sw(12, 3), h);
    chk_eq("R9", "hold store rt", h, 1);
    issue(f_sw(12, 3), h);
    chk_eq("R9", "store replay", h, 0);
    flush();
    issue(f_lw(13, 1), h);
    issue(f_beq(3, 13), h);
    chk_eq("R9", "hold beq rt", h, 1);
    issue(f_beq(3, 13), h);
    flush();
    issue(f_lw(14, 1), h);
    issue(f_reg(4, 2, 14), h);
    chk_eq("R9", "hold reg rt", h, 1);
    issue(f_reg(4, 2, 14), h);
    flush();
  endtask

  task automatic t_no_hazard();
    bit h;
    issue(f_lw(0, 1), h);
    issue(f_reg(4, 0, 0), h);
    chk_eq("R11", "load to r0", h, 0);
    flush();
    issue(f_lw(15, 1), h);
    issue(f_lw(15, 5), h);
    chk_eq("R11", "load rt not a source", h, 0);
    flush();
    issue(f_lw(16, 1), h);
    issue(f_lw(2, 16), h);
    chk_eq("R9", "load rs match", h, 1);
    issue(f_lw(2, 16), h);
    flush();
    issue(f_lw(17, 1), h);
    issue(NOP, h);
    issue(f_reg(18, 17, 17), h);
    chk_eq("R12", "two slots behind", h, 0);
    chk_ex("R12", 1, 2, 0, 18);
    flush();
  endtask

  initial begin
    t_reset();
    @(negedge clk);
    t_reg();
    t_load();
    t_store();
    t_beq();
    t_other();
    t_back_to_back();
    t_load_use_rs();
    t_load_use_rt();
    t_no_hazard();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule